// File: doc/BRIEF.md
# Preserved Program Order Checker

This block takes two memory operations from one hart, an older operation A and a younger operation B, and decides whether B has to stay behind A. A load/store queue can use the answer to block a reordering that would break the memory model. Each operation arrives with its access kind, the index of its aligned address granule, a byte mask inside that granule, acquire and release annotations with a strength flag, and an I/O-region bit. Along with the two operations come the pair-level facts that a dependency tracker and the queue already hold: fence sets between A and B, LR/SC pairing, syntactic dependencies, intermediate-instruction dependencies and load value sources.

The block registers its answer one cycle after a request. The answer is a must-order bit and a two-bit code for the rule family that forced the order. When several families apply, the lowest code wins. The block does not track global memory order and does not model other harts.

Top module: `ppo_checker`

## Requirements
- R1: If A or B lies in an I/O region (`a_io` or `b_io` high), `must_order` is 0 and `rule_cat` is 0, whatever else is asserted.
- R2: Kind bit 0 means read and bit 1 means write; an AMO has both bits set. A B that writes, and touches a byte that A touches (same granule index, non-zero mask AND), is ordered with code 0.
- R3: When A and B both read, share a byte, `ld_src_differ` is 1 and `ld_store_between` is 0, B is ordered with code 0. If `ld_store_between` is 1, this rule does not apply.
- R4: A reading B whose value comes from A (`b_reads_a`) is ordered with code 0 when A came from an AMO or store-conditional (`a_amo_sc`).
- R5: With `fence_vld`, B is ordered with code 1 when `a_kind & fence_pred` and `b_kind & fence_succ` are both non-zero. The fence sets use the same bit encoding as the kinds.
- R6: An acquire on A orders B, and a release on B orders it after A; both give code 1.
- R7: B is ordered with code 1 when both operations carry a strong (RCsc) annotation, and also when `pair_lrsc` is set. Two weak (RCpc) annotations alone do not order B.
- R8: An address dependency of B on A orders B with code 2. A data dependency or a control dependency orders B with code 2 only when B writes.
- R9: Code 3 applies when B writes and `mid_addr_dep` is set, or when B reads and `mid_st_fwd` is set.
- R10: Codes are overlap 0, synchronisation 1, syntactic 2, pipeline 3. When rules from more than one family apply, the lowest code is reported.
- R11: `ord_valid`, `must_order` and `rule_cat` show the request from the previous clock edge. A cycle without `req_valid` gives 0 on all three one cycle later.
- R12: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A pair is presented this cycle |
| a_kind | input | 2 | Kind of A: bit 0 read, bit 1 write |
| a_gran | input | GRAN_W | Aligned granule index of A |
| a_mask | input | MASK_W | Bytes of the granule touched by A |
| a_io | input | 1 | A is in an I/O region |
| a_acq | input | 1 | A has an acquire annotation |
| a_acq_sc | input | 1 | A's acquire is strong (RCsc) |
| a_rel | input | 1 | A has a release annotation |
| a_rel_sc | input | 1 | A's release is strong (RCsc) |
| a_amo_sc | input | 1 | A comes from an AMO or store-conditional |
| b_kind | input | 2 | Kind of B: bit 0 read, bit 1 write |
| b_gran | input | GRAN_W | Aligned granule index of B |
| b_mask | input | MASK_W | Bytes of the granule touched by B |
| b_io | input | 1 | B is in an I/O region |
| b_acq | input | 1 | B has an acquire annotation |
| b_acq_sc | input | 1 | B's acquire is strong (RCsc) |
| b_rel | input | 1 | B has a release annotation |
| b_rel_sc | input | 1 | B's release is strong (RCsc) |
| b_reads_a | input | 1 | B returns a value written by A |
| pair_lrsc | input | 1 | A and B are a paired LR/SC |
| fence_vld | input | 1 | A fence lies between A and B |
| fence_pred | input | 2 | Fence predecessor set (bit 0 read, bit 1 write) |
| fence_succ | input | 2 | Fence successor set (bit 0 read, bit 1 write) |
| ld_store_between | input | 1 | A store to the shared byte lies between two reads |
| ld_src_differ | input | 1 | The two reads take the shared byte from different writers |
| dep_addr | input | 1 | B has an address dependency on A |
| dep_data | input | 1 | B has a data dependency on A |
| dep_ctrl | input | 1 | B has a control dependency on A |
| mid_addr_dep | input | 1 | An instruction between A and B has an address dependency on A |
| mid_st_fwd | input | 1 | B returns a value from an intermediate store that depends on A |
| ord_valid | output | 1 | Registered result is valid |
| must_order | output | 1 | B must stay after A |
| rule_cat | output | 2 | Rule family of the order (0..3) |

## Verification
On every cycle the assertions check the I/O gate, the store-overlap rule with its code, the acquire and paired LR/SC rules, the code bound for address dependencies, and the idle behaviour of the output register. How the families rank against each other when several apply, the weak-annotation case, the load-load exception for an intervening store, and the fence set matching can only be shown by the bench's directed scenarios and its random pairs. The random pairs are checked against a reference computed from the requirements.

// File: rtl/ppo_pkg.sv
// Package: shared types for the preserved-program-order checker.
// Kind and fence set vectors use bit 0 for read and bit 1 for write.
package ppo_pkg;
    localparam int KIND_RD = 0;
    localparam int KIND_WR = 1;

    typedef enum logic [1:0] {
        CAT_OVERLAP = 2'd0,
        CAT_SYNC    = 2'd1,
        CAT_SYNTAX  = 2'd2,
        CAT_PIPE    = 2'd3
    } ppo_cat_e;

    typedef struct packed {
        logic acq;
        logic acq_sc;
        logic rel;
        logic rel_sc;
    } ppo_anno_t;
endpackage

// File: rtl/ppo_overlap_rules.sv
// Module: overlap-address rule family.
// Assumes the addresses are given as aligned granule indices, with byte masks inside the granule.
module ppo_overlap_rules
    import ppo_pkg::*;
#(
    parameter int GRAN_W = 29,
    parameter int MASK_W = 8
) (
    input  logic [1:0]        a_kind,
    input  logic [1:0]        b_kind,
    input  logic [GRAN_W-1:0] a_gran,
    input  logic [GRAN_W-1:0] b_gran,
    input  logic [MASK_W-1:0] a_mask,
    input  logic [MASK_W-1:0] b_mask,
    input  logic              a_amo_sc,
    input  logic              b_reads_a,
    input  logic              ld_store_between,
    input  logic              ld_src_differ,
    output logic              hit
);
    logic [MASK_W-1:0] shared_byte;
    logic              same_gran;
    logic              any_shared;

    // Mark, for each byte lane, whether both operations touch it.
    for (genvar i = 0; i < MASK_W; i++) begin : g_lane
        assign shared_byte[i] = a_mask[i] & b_mask[i];
    end

    assign same_gran  = (a_gran == b_gran);
    assign any_shared = same_gran && (|shared_byte);

    // Combine the three overlap rules.
    always_comb begin
        hit = 1'b0;
        if (b_kind[KIND_WR] && any_shared)
            hit = 1'b1;
        if (a_kind[KIND_RD] && b_kind[KIND_RD] && any_shared &&
            !ld_store_between && ld_src_differ)
            hit = 1'b1;
        if (a_amo_sc && b_kind[KIND_RD] && b_reads_a)
            hit = 1'b1;
    end
endmodule

// File: rtl/ppo_sync_rules.sv
// Module: explicit-synchronisation rule family (fence, annotations, LR/SC pairing).
// Assumes the fence sets share the kind encoding.
module ppo_sync_rules
    import ppo_pkg::*;
(
    input  logic [1:0] a_kind,
    input  logic [1:0] b_kind,
    input  ppo_anno_t  a_anno,
    input  ppo_anno_t  b_anno,
    input  logic       pair_lrsc,
    input  logic       fence_vld,
    input  logic [1:0] fence_pred,
    input  logic [1:0] fence_succ,
    output logic       hit
);
    logic fence_hit;
    logic a_strong;
    logic b_strong;

    // Match the fence's sets against the kinds of the two operations.
    always_comb begin
        fence_hit = fence_vld && (|(a_kind & fence_pred)) && (|(b_kind & fence_succ));
    end

    // Decide whether each side carries at least one strong annotation.
    always_comb begin
        a_strong = (a_anno.acq && a_anno.acq_sc) || (a_anno.rel && a_anno.rel_sc);
        b_strong = (b_anno.acq && b_anno.acq_sc) || (b_anno.rel && b_anno.rel_sc);
    end

    // Combine the synchronisation rules.
    always_comb begin
        hit = fence_hit || a_anno.acq || b_anno.rel || (a_strong && b_strong) || pair_lrsc;
    end
endmodule

// File: rtl/ppo_dep_rules.sv
// Module: syntactic and pipeline dependency rule families.
// Assumes the dependency flags come from an upstream tracker and describe B relative to A.
module ppo_dep_rules
    import ppo_pkg::*;
(
    input  logic [1:0] b_kind,
    input  logic       dep_addr,
    input  logic       dep_data,
    input  logic       dep_ctrl,
    input  logic       mid_addr_dep,
    input  logic       mid_st_fwd,
    output logic       syn_hit,
    output logic       pipe_hit
);
    // Syntactic dependencies: data and control dependencies count only for a writing B.
    always_comb begin
        syn_hit = dep_addr || (b_kind[KIND_WR] && (dep_data || dep_ctrl));
    end

    // Pipeline dependencies through an intermediate instruction.
    always_comb begin
        pipe_hit = (b_kind[KIND_WR] && mid_addr_dep) || (b_kind[KIND_RD] && mid_st_fwd);
    end
endmodule

// File: rtl/ppo_checker.sv
// Module: top of the preserved-program-order checker.
// Evaluates all four rule families for an older/younger pair. It gates the result off for
// I/O regions, picks the lowest family code and registers the answer one cycle later.
module ppo_checker
    import ppo_pkg::*;
#(
    parameter int GRAN_W = 29,
    parameter int MASK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        a_kind,
    input  logic [GRAN_W-1:0] a_gran,
    input  logic [MASK_W-1:0] a_mask,
    input  logic              a_io,
    input  logic              a_acq,
    input  logic              a_acq_sc,
    input  logic              a_rel,
    input  logic              a_rel_sc,
    input  logic              a_amo_sc,
    input  logic [1:0]        b_kind,
    input  logic [GRAN_W-1:0] b_gran,
    input  logic [MASK_W-1:0] b_mask,
    input  logic              b_io,
    input  logic              b_acq,
    input  logic              b_acq_sc,
    input  logic              b_rel,
    input  logic              b_rel_sc,
    input  logic              b_reads_a,
    input  logic              pair_lrsc,
    input  logic              fence_vld,
    input  logic [1:0]        fence_pred,
    input  logic [1:0]        fence_succ,
    input  logic              ld_store_between,
    input  logic              ld_src_differ,
    input  logic              dep_addr,
    input  logic              dep_data,
    input  logic              dep_ctrl,
    input  logic              mid_addr_dep,
    input  logic              mid_st_fwd,
    output logic              ord_valid,
    output logic              must_order,
    output logic [1:0]        rule_cat
);
    ppo_anno_t a_anno;
    ppo_anno_t b_anno;
    logic      ov_hit;
    logic      sy_hit;
    logic      syn_hit;
    logic      pipe_hit;
    logic      order_nxt;
    ppo_cat_e  cat_nxt;

    assign a_anno = '{acq: a_acq, acq_sc: a_acq_sc, rel: a_rel, rel_sc: a_rel_sc};
    assign b_anno = '{acq: b_acq, acq_sc: b_acq_sc, rel: b_rel, rel_sc: b_rel_sc};

    ppo_overlap_rules #(.GRAN_W(GRAN_W), .MASK_W(MASK_W)) u_overlap (
        .a_kind           (a_kind),
        .b_kind           (b_kind),
        .a_gran           (a_gran),
        .b_gran           (b_gran),
        .a_mask           (a_mask),
        .b_mask           (b_mask),
        .a_amo_sc         (a_amo_sc),
        .b_reads_a        (b_reads_a),
        .ld_store_between (ld_store_between),
        .ld_src_differ    (ld_src_differ),
        .hit              (ov_hit)
    );

    ppo_sync_rules u_sync (
        .a_kind     (a_kind),
        .b_kind     (b_kind),
        .a_anno     (a_anno),
        .b_anno     (b_anno),
        .pair_lrsc  (pair_lrsc),
        .fence_vld  (fence_vld),
        .fence_pred (fence_pred),
        .fence_succ (fence_succ),
        .hit        (sy_hit)
    );

    ppo_dep_rules u_dep (
        .b_kind       (b_kind),
        .dep_addr     (dep_addr),
        .dep_data     (dep_data),
        .dep_ctrl     (dep_ctrl),
        .mid_addr_dep (mid_addr_dep),
        .mid_st_fwd   (mid_st_fwd),
        .syn_hit      (syn_hit),
        .pipe_hit     (pipe_hit)
    );

    // Gate for I/O regions and pick the lowest family code that applies.
    always_comb begin
        order_nxt = 1'b0;
        cat_nxt   = CAT_OVERLAP;
        if (!a_io && !b_io) begin
            if (ov_hit) begin
                order_nxt = 1'b1;
                cat_nxt   = CAT_OVERLAP;
            end else if (sy_hit) begin
                order_nxt = 1'b1;
                cat_nxt   = CAT_SYNC;
            end else if (syn_hit) begin
                order_nxt = 1'b1;
                cat_nxt   = CAT_SYNTAX;
            end else if (pipe_hit) begin
                order_nxt = 1'b1;
                cat_nxt   = CAT_PIPE;
            end
        end
    end

    // Register the answer; with no request the outputs fall back to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ord_valid  <= 1'b0;
            must_order <= 1'b0;
            rule_cat   <= 2'd0;
        end else begin
            ord_valid  <= req_valid;
            must_order <= req_valid && order_nxt;
            rule_cat   <= (req_valid && order_nxt) ? cat_nxt : 2'd0;
        end
    end
endmodule

// File: rtl/ppo_checker_sva.sv
// Module: assertion checker for ppo_checker, attached through bind.
// Assumes the same kind encoding and granule/mask address form as the top module.
module ppo_checker_sva #(
    parameter int GRAN_W = 29,
    parameter int MASK_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        b_kind,
    input logic [GRAN_W-1:0] a_gran,
    input logic [GRAN_W-1:0] b_gran,
    input logic [MASK_W-1:0] a_mask,
    input logic [MASK_W-1:0] b_mask,
    input logic              a_io,
    input logic              b_io,
    input logic              a_acq,
    input logic              pair_lrsc,
    input logic              dep_addr,
    input logic              ord_valid,
    input logic              must_order,
    input logic [1:0]        rule_cat
);
    logic mem_pair;
    assign mem_pair = req_valid && !a_io && !b_io;

    AST_IO_NO_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (a_io || b_io)) |=> (!must_order && rule_cat == 2'd0)); // R1

    AST_STORE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_pair && b_kind[1] && a_gran == b_gran && (|(a_mask & b_mask)))
        |=> (must_order && rule_cat == 2'd0)); // R2

    AST_ACQUIRE_ORDERS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_pair && a_acq) |=> (must_order && rule_cat <= 2'd1)); // R6

    AST_PAIR_ORDERS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_pair && pair_lrsc) |=> (must_order && rule_cat <= 2'd1)); // R7

    AST_ADDR_DEP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_pair && dep_addr) |=> (must_order && rule_cat <= 2'd2)); // R8

    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!ord_valid && !must_order && rule_cat == 2'd0)); // R11

    AST_ORDER_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        must_order |-> ord_valid); // R11
endmodule

bind ppo_checker ppo_checker_sva #(.GRAN_W(GRAN_W), .MASK_W(MASK_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .b_kind     (b_kind),
    .a_gran     (a_gran),
    .b_gran     (b_gran),
    .a_mask     (a_mask),
    .b_mask     (b_mask),
    .a_io       (a_io),
    .b_io       (b_io),
    .a_acq      (a_acq),
    .pair_lrsc  (pair_lrsc),
    .dep_addr   (dep_addr),
    .ord_valid  (ord_valid),
    .must_order (must_order),
    .rule_cat   (rule_cat)
);

// File: tb/test_ppo_checker.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random pairs, checked against a reference model.
module test_ppo_checker;
    localparam int GRAN_W = 29;
    localparam int MASK_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid;
    logic [1:0] a_kind, b_kind, fence_pred, fence_succ;
    logic [GRAN_W-1:0] a_gran, b_gran;
    logic [MASK_W-1:0] a_mask, b_mask;
    logic a_io, a_acq, a_acq_sc, a_rel, a_rel_sc, a_amo_sc;
    logic b_io, b_acq, b_acq_sc, b_rel, b_rel_sc, b_reads_a;
    logic pair_lrsc, fence_vld, ld_store_between, ld_src_differ;
    logic dep_addr, dep_data, dep_ctrl, mid_addr_dep, mid_st_fwd;
    logic ord_valid, must_order;
    logic [1:0] rule_cat;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ppo_checker #(.GRAN_W(GRAN_W), .MASK_W(MASK_W)) i_ppo_checker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .a_kind(a_kind), .a_gran(a_gran), .a_mask(a_mask), .a_io(a_io),
        .a_acq(a_acq), .a_acq_sc(a_acq_sc), .a_rel(a_rel), .a_rel_sc(a_rel_sc),
        .a_amo_sc(a_amo_sc),
        .b_kind(b_kind), .b_gran(b_gran), .b_mask(b_mask), .b_io(b_io),
        .b_acq(b_acq), .b_acq_sc(b_acq_sc), .b_rel(b_rel), .b_rel_sc(b_rel_sc),
        .b_reads_a(b_reads_a), .pair_lrsc(pair_lrsc), .fence_vld(fence_vld),
        .fence_pred(fence_pred), .fence_succ(fence_succ),
        .ld_store_between(ld_store_between), .ld_src_differ(ld_src_differ),
        .dep_addr(dep_addr), .dep_data(dep_data), .dep_ctrl(dep_ctrl),
        .mid_addr_dep(mid_addr_dep), .mid_st_fwd(mid_st_fwd),
        .ord_valid(ord_valid), .must_order(must_order), .rule_cat(rule_cat)
    );

    // Reference model written from the requirements: returns {order, code}.
    function automatic logic [2:0] ref_eval();
        logic share, ov, sy, syn, pipe, sa, sb;
        share = (a_gran == b_gran) && (|(a_mask & b_mask));
        ov  = (b_kind[1] && share)
            || (a_kind[0] && b_kind[0] && share && !ld_store_between && ld_src_differ)
            || (a_amo_sc && b_kind[0] && b_reads_a);
        sa  = (a_acq && a_acq_sc) || (a_rel && a_rel_sc);
        sb  = (b_acq && b_acq_sc) || (b_rel && b_rel_sc);
        sy  = (fence_vld && (|(a_kind & fence_pred)) && (|(b_kind & fence_succ)))
            || a_acq || b_rel || (sa && sb) || pair_lrsc;
        syn = dep_addr || (b_kind[1] && (dep_data || dep_ctrl));
        pipe = (b_kind[1] && mid_addr_dep) || (b_kind[0] && mid_st_fwd);
        if (a_io || b_io) return 3'b000;
        if (ov)   return 3'b100;
        if (sy)   return 3'b101;
        if (syn)  return 3'b110;
        if (pipe) return 3'b111;
        return 3'b000;
    endfunction

    task automatic clear_inputs();
        req_valid = 1'b0;
        a_kind = 2'b01; b_kind = 2'b01; fence_pred = 2'b00; fence_succ = 2'b00;
        a_gran = '0; b_gran = 29'd1; a_mask = 8'h00; b_mask = 8'h00;
        a_io = 0; a_acq = 0; a_acq_sc = 0; a_rel = 0; a_rel_sc = 0; a_amo_sc = 0;
        b_io = 0; b_acq = 0; b_acq_sc = 0; b_rel = 0; b_rel_sc = 0; b_reads_a = 0;
        pair_lrsc = 0; fence_vld = 0; ld_store_between = 0; ld_src_differ = 0;
        dep_addr = 0; dep_data = 0; dep_ctrl = 0; mid_addr_dep = 0; mid_st_fwd = 0;
    endtask

    task automatic check(string req, logic exp_v, logic exp_o, logic [1:0] exp_c);
        n_checks++;
        if (ord_valid !== exp_v || must_order !== exp_o || rule_cat !== exp_c) begin
            n_fail++;
            $display("FAIL %s: got valid=%b order=%b code=%0d, expected valid=%b order=%b code=%0d",
                     req, ord_valid, must_order, rule_cat, exp_v, exp_o, exp_c);
        end
    endtask

    // Present the current inputs for one cycle and check against the reference.
    task automatic apply(string req);
        logic [2:0] e;
        req_valid = 1'b1;
        e = ref_eval();
        @(negedge clk);
        check(req, 1'b1, e[2], e[1:0]);
    endtask

    // Present the current inputs and check against a stated result.
    task automatic apply_exp(string req, logic exp_o, logic [1:0] exp_c);
        req_valid = 1'b1;
        @(negedge clk);
        check(req, 1'b1, exp_o, exp_c);
    endtask

    initial begin
        #(5ns * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: got running, expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_inputs();
        req_valid = 1'b1;
        b_kind = 2'b10; b_gran = '0; a_mask = 8'hFF; b_mask = 8'hFF; a_acq = 1;
        repeat (3) @(negedge clk);
        check("R12 reset", 1'b0, 1'b0, 2'd0);
        clear_inputs();
        rst_n = 1'b1;
        @(negedge clk);

        // R2: writing B overlapping one byte
        clear_inputs(); b_kind = 2'b10; b_gran = '0; a_mask = 8'h0C; b_mask = 8'h08;
        apply_exp("R2 store overlap", 1'b1, 2'd0);
        // R2: disjoint masks in the same granule
        b_mask = 8'h30;
        apply_exp("R2 disjoint bytes", 1'b0, 2'd0);
        // R1: I/O region suppresses an overlap and an acquire
        clear_inputs(); b_kind = 2'b10; b_gran = '0; a_mask = 8'hFF; b_mask = 8'hFF;
        a_acq = 1; b_io = 1;
        apply_exp("R1 io region", 1'b0, 2'd0);
        b_io = 0; a_io = 1;
        apply_exp("R1 io region older", 1'b0, 2'd0);
        // R3: load-load with different writers
        clear_inputs(); b_gran = '0; a_mask = 8'h01; b_mask = 8'h03; ld_src_differ = 1;
        apply_exp("R3 load-load", 1'b1, 2'd0);
        ld_store_between = 1;
        apply_exp("R3 store between", 1'b0, 2'd0);
        // R4: read from older AMO
        clear_inputs(); a_kind = 2'b11; a_amo_sc = 1; b_reads_a = 1;
        apply_exp("R4 amo forward", 1'b1, 2'd0);
        // R5: fence write->read matches; read->read does not
        clear_inputs(); a_kind = 2'b10; fence_vld = 1; fence_pred = 2'b10; fence_succ = 2'b01;
        apply_exp("R5 fence match", 1'b1, 2'd1);
        fence_pred = 2'b01;
        apply_exp("R5 fence miss", 1'b0, 2'd0);
        // R6: acquire on A, release on B
        clear_inputs(); a_acq = 1;
        apply_exp("R6 acquire", 1'b1, 2'd1);
        clear_inputs(); b_rel = 1;
        apply_exp("R6 release", 1'b1, 2'd1);
        // R7: strong vs weak annotation pairs, paired LR/SC
        clear_inputs(); a_rel = 1; a_rel_sc = 1; b_acq = 1; b_acq_sc = 1;
        apply_exp("R7 rcsc pair", 1'b1, 2'd1);
        a_rel_sc = 0; b_acq_sc = 0;
        apply_exp("R7 rcpc pair", 1'b0, 2'd0);
        clear_inputs(); pair_lrsc = 1;
        apply_exp("R7 paired lrsc", 1'b1, 2'd1);
        // R8: address dependency; control dependency needs writing B
        clear_inputs(); dep_addr = 1;
        apply_exp("R8 addr dep", 1'b1, 2'd2);
        clear_inputs(); dep_ctrl = 1; dep_data = 1;
        apply_exp("R8 ctrl on read", 1'b0, 2'd0);
        b_kind = 2'b10;
        apply_exp("R8 ctrl on write", 1'b1, 2'd2);
        // R9: pipeline rules
        clear_inputs(); mid_st_fwd = 1;
        apply_exp("R9 forward from mid store", 1'b1, 2'd3);
        clear_inputs(); b_kind = 2'b10; mid_addr_dep = 1;
        apply_exp("R9 mid addr dep", 1'b1, 2'd3);
        mid_addr_dep = 0; mid_st_fwd = 1;
        apply_exp("R9 forward on write", 1'b0, 2'd0);
        // R10: priority between families
        clear_inputs(); b_kind = 2'b10; b_gran = '0; a_mask = 8'h80; b_mask = 8'h80;
        a_acq = 1; dep_addr = 1; mid_addr_dep = 1;
        apply_exp("R10 overlap wins", 1'b1, 2'd0);
        b_mask = 8'h40;
        apply_exp("R10 sync wins", 1'b1, 2'd1);
        a_acq = 0;
        apply_exp("R10 syntactic wins", 1'b1, 2'd2);
        // R11: idle cycle clears outputs
        req_valid = 1'b0;
        @(negedge clk);
        check("R11 idle", 1'b0, 1'b0, 2'd0);

        // Random pairs: R1..R10 against the reference model
        for (int n = 0; n < 3000; n++) begin
            clear_inputs();
            a_kind = 2'(1 + $urandom_range(0, 2));
            b_kind = 2'(1 + $urandom_range(0, 2));
            a_gran = 29'($urandom_range(0, 1));
            b_gran = 29'($urandom_range(0, 1));
            a_mask = 8'($urandom); b_mask = 8'($urandom);
            a_io = ($urandom_range(0, 15) == 0); b_io = ($urandom_range(0, 15) == 0);
            a_acq = ($urandom_range(0, 7) == 0); a_acq_sc = 1'($urandom);
            a_rel = ($urandom_range(0, 3) == 0); a_rel_sc = 1'($urandom);
            b_acq = ($urandom_range(0, 3) == 0); b_acq_sc = 1'($urandom);
            b_rel = ($urandom_range(0, 7) == 0); b_rel_sc = 1'($urandom);
            a_amo_sc = 1'($urandom); b_reads_a = ($urandom_range(0, 3) == 0);
            pair_lrsc = ($urandom_range(0, 15) == 0);
            fence_vld = ($urandom_range(0, 3) == 0);
            fence_pred = 2'($urandom); fence_succ = 2'($urandom);
            ld_store_between = 1'($urandom); ld_src_differ = 1'($urandom);
            dep_addr = ($urandom_range(0, 7) == 0); dep_data = ($urandom_range(0, 5) == 0);
            dep_ctrl = ($urandom_range(0, 5) == 0); mid_addr_dep = ($urandom_range(0, 3) == 0);
            mid_st_fwd = ($urandom_range(0, 3) == 0);
            apply("R10 random pair (R1-related gating, R2 R3 R4 R5 R6 R7 R8 R9)");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule